// File: doc/BRIEF.md
# I/O Page Table Walker

This block turns an I/O virtual address, aligned to 4 KiB, into a system physical address. It walks a multi-level translation table in memory. The walk starts from a table pointer and a starting level, both taken from an already fetched device context. Each step reads one 64-bit entry through a simple request/response memory port and then decides whether to descend, finish or fault. Before it trusts an entry, the walker checks the entry's level code, its reserved bits and its permissions. Directory entries may skip intermediate levels. Final entries may map a page of the level's natural size or of a larger encoded size.

A result comes back on a one-cycle valid pulse. It carries one of three outcomes. A successful walk gives the page base, the page-size shift, the granted permissions and the full physical address. A fault gives a record with the requester's device and domain identifiers, the address, three flag bits and a fault-type code. A memory read error gives a separate error status. Only one walk is in flight at a time.

Entry layout: bits [11:9] hold the next-level code. Bits [51:12] hold the address field. Bit 61 is read permission and bit 62 is write permission. Requested permissions use the same order: bit 0 is read and bit 1 is write. Level L indexes the nine address bits starting at bit 12+9(L-1). The start level must lie between 1 and MAX_LEVEL.

Top module: `io_pt_walker`

## Requirements
- R1: At level L the walker reads exactly one entry, at the table address plus 8 times the nine-bit index taken from the address at bit 12+9(L-1). A walk that ends at level M issues one read per level visited.
- R2: A directory code from 1 to 6 that exceeds MAX_LEVEL ends the walk with fault type 1, and with the present and reserved flags set.
- R3: Entries with code 0 or 7 are tested against the page reserved mask, and all other entries against the directory reserved mask. Any hit gives fault type 2 with the reserved flag set.
- R4: Every requested permission bit must also be set in each entry visited, otherwise the walk gives fault type 3 with the permission-denied flag set. A successful walk reports the final entry's permission bits.
- R5: Code 0 finishes with the current level's shift, 12+9(L-1). The base is the address field with the bits below that shift cleared.
- R6: Code 7 scans the address field upward from bit 12 and stops at the first clear bit k, which gives shift k+1. This shift must be strictly above the current level's shift and strictly below the next higher level's shift; at level 6 it never is. A failure gives fault type 4 with only the present flag set.
- R7: A directory code that is not below the current level gives fault type 5.
- R8: When a directory moves from level L to level N, the address bits of every level between them must be zero. The mask is (4096<<9(L-1))-(4096<<9N). Otherwise the walk gives fault type 6.
- R9: On success the physical address is the base ORed with the address bits below the shift.
- R10: A fault (status 1) reports the request's device ID, domain ID and address, with the present flag set.
- R11: A read answered with an error ends the walk with status 2.
- R12: A request is accepted only while idle. At most one read is outstanding, and the request pulse lasts one cycle. The result pulse lasts one cycle and is followed by idle.
- R13: The checks apply in a fixed order: level code, reserved bits, permission, then page size, or else level transition and skipped bits. Only the first failing check is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start a walk |
| reqReady | output | 1 | Walker idle, request accepted |
| reqIova | input | 64 | Address to translate |
| reqPerm | input | 2 | Requested permissions (bit0 read, bit1 write) |
| reqDevId | input | ID_W | Requester device identifier |
| reqDomain | input | ID_W | Requester domain identifier |
| rootAddr | input | 64 | Root table address |
| rootLevel | input | 3 | Starting level |
| memReqValid | output | 1 | Entry read request |
| memReqAddr | output | 64 | Entry read address |
| memRspValid | input | 1 | Read response strobe |
| memRspData | input | 64 | Entry returned |
| memRspErr | input | 1 | Read failed |
| resValid | output | 1 | Result pulse |
| resStatus | output | 2 | 0 ok, 1 fault, 2 read error |
| resPhysAddr | output | 64 | Translated address |
| resPageBase | output | 64 | Page base |
| resShift | output | 7 | Page-size shift |
| resPerm | output | 2 | Granted permissions |
| resFaultType | output | 3 | Fault type code |
| resPresent | output | 1 | Fault flag: entry present |
| resRsvd | output | 1 | Fault flag: reserved bits or bad encoding |
| resPermDenied | output | 1 | Fault flag: permission denied |
| resDevId | output | ID_W | Device ID of the walk |
| resDomain | output | ID_W | Domain ID of the walk |
| resIova | output | 64 | Address of the walk |

## Verification
The bench builds the walker with MAX_LEVEL set to 4. With that setting, directory codes 5 and 6 become invalid encodings, so the encoding fault can be produced. The bench starts walks at level 3 and at level 4, which brings two-level skips, 1 GiB and 512 GiB natural pages, and enlarged pages at three levels within reach. It sweeps index combinations and all four permission requests over tables placed in a small model memory, with response latency varying by address. It compares every result against an arithmetic walk computed in the bench.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  localparam int ENT_W = 64;

  localparam logic [1:0] ST_OK     = 2'd0;
  localparam logic [1:0] ST_FAULT  = 2'd1;
  localparam logic [1:0] ST_BUSERR = 2'd2;

  localparam logic [2:0] FT_NONE  = 3'd0;
  localparam logic [2:0] FT_LEVEL = 3'd1;
  localparam logic [2:0] FT_RSVD  = 3'd2;
  localparam logic [2:0] FT_PERM  = 3'd3;
  localparam logic [2:0] FT_SIZE  = 3'd4;
  localparam logic [2:0] FT_TRANS = 3'd5;
  localparam logic [2:0] FT_SKIP  = 3'd6;

  typedef enum logic [1:0] {EV_DESCEND, EV_FINAL, EV_FAULT} evalKind_e;

  typedef struct packed {
    logic load;
    logic step;
    logic endOk;
    logic endFault;
    logic endBus;
  } walkCtrl_t;

  // natural shift of a table level (0 for codes outside 1..6)
  function automatic logic [6:0] levelShift(input logic [2:0] lvl);
    if (lvl == 3'd0 || lvl == 3'd7) return 7'd0;
    return 7'(12 + 9 * (int'(lvl) - 1));
  endfunction

  // highest address covered below level x (x at most 5 here)
  function automatic logic [63:0] maxIova(input logic [2:0] x);
    return (64'd4096 << (9 * int'(x))) - 64'd1;
  endfunction
endpackage

// File: rtl/iopt_ctrl.sv
module iopt_ctrl
  import iopt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      memRspValid,
  input  logic      memRspErr,
  input  evalKind_e evalKind,
  output walkCtrl_t ctrl,
  output logic      reqReady,
  output logic      memReqValid,
  output logic      resValid
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_e;
  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      S_IDLE: if (reqValid) begin
        ctrl.load = 1'b1;
        stateNext = S_ISSUE;
      end
      S_ISSUE: stateNext = S_WAIT;
      S_WAIT: if (memRspValid) begin
        if (memRspErr) begin
          ctrl.endBus = 1'b1;
          stateNext   = S_RESP;
        end else if (evalKind == EV_FAULT) begin
          ctrl.endFault = 1'b1;
          stateNext     = S_RESP;
        end else if (evalKind == EV_FINAL) begin
          ctrl.endOk = 1'b1;
          stateNext  = S_RESP;
        end else begin
          ctrl.step = 1'b1;
          stateNext = S_ISSUE;
        end
      end
      S_RESP: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_ISSUE);
  assign resValid    = (state == S_RESP);
endmodule

// File: rtl/iopt_dpath.sv
module iopt_dpath
  import iopt_pkg::*;
#(
  parameter int          MAX_LEVEL = 6,
  parameter int          ID_W      = 16,
  parameter logic [63:0] ADDR_MASK = 64'h000F_FFFF_FFFF_F000,
  parameter logic [63:0] PTE_RSVD  = 64'h07F0_0000_0000_0000,
  parameter logic [63:0] PDE_RSVD  = 64'h1FF0_0000_0000_0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  walkCtrl_t       ctrl,
  input  logic [63:0]     reqIova,
  input  logic [1:0]      reqPerm,
  input  logic [ID_W-1:0] reqDevId,
  input  logic [ID_W-1:0] reqDomain,
  input  logic [63:0]     rootAddr,
  input  logic [2:0]      rootLevel,
  input  logic [ENT_W-1:0] memRspData,
  output evalKind_e       evalKind,
  output logic [63:0]     memReqAddr,
  output logic [1:0]      resStatus,
  output logic [63:0]     resPhysAddr,
  output logic [63:0]     resPageBase,
  output logic [6:0]      resShift,
  output logic [1:0]      resPerm,
  output logic [2:0]      resFaultType,
  output logic            resPresent,
  output logic            resRsvd,
  output logic            resPermDenied,
  output logic [ID_W-1:0] resDevId,
  output logic [ID_W-1:0] resDomain,
  output logic [63:0]     resIova
);
  localparam int IDX_W = 9;

  logic [63:0] iovaQ, tblAddrQ;
  logic [1:0]  permQ;
  logic [2:0]  levelQ;

  logic [2:0]  nxt;
  logic [63:0] addrF, skipMask, pageBase, lowMask;
  logic [1:0]  ePerm;
  logic        isPage, badLvl, rsvdHit, permBad, sizeBad, transBad, skipBad;
  logic [6:0]  curShift, upShift, scanK, bigShift, pageShift;
  logic [2:0]  faultType;
  logic [IDX_W-1:0] idx;

  assign curShift   = levelShift(levelQ);
  assign idx        = IDX_W'(iovaQ >> curShift);
  assign memReqAddr = tblAddrQ + (64'(idx) << 3);

  always_comb begin
    nxt      = memRspData[11:9];
    addrF    = memRspData & ADDR_MASK;
    ePerm    = memRspData[62:61];
    isPage   = (nxt == 3'd0) || (nxt == 3'd7);
    badLvl   = !isPage && (int'(nxt) > MAX_LEVEL);
    rsvdHit  = |(memRspData & (isPage ? PTE_RSVD : PDE_RSVD));
    permBad  = (permQ & ePerm) != permQ;
    upShift  = (levelQ >= 3'd6) ? 7'd0 : levelShift(levelQ + 3'd1);
    scanK    = 7'd63;
    for (int i = 63; i >= 12; i--) begin
      if (!addrF[i]) scanK = 7'(i);
    end
    bigShift  = scanK + 7'd1;
    sizeBad   = (nxt == 3'd7) && !((bigShift > curShift) && (bigShift < upShift));
    transBad  = !isPage && (nxt >= levelQ);
    skipMask  = (!isPage && !transBad) ? (maxIova(levelQ - 3'd1) - maxIova(nxt)) : 64'd0;
    skipBad   = |(iovaQ & skipMask);
    pageShift = (nxt == 3'd0) ? curShift : bigShift;
    lowMask   = ~(~64'd0 << pageShift);
    pageBase  = addrF & ~lowMask;

    faultType = FT_NONE;
    evalKind  = EV_DESCEND;
    if (badLvl)                 faultType = FT_LEVEL;
    else if (rsvdHit)           faultType = FT_RSVD;
    else if (permBad)           faultType = FT_PERM;
    else if (isPage && sizeBad) faultType = FT_SIZE;
    else if (transBad)          faultType = FT_TRANS;
    else if (skipBad)           faultType = FT_SKIP;
    if (faultType != FT_NONE) evalKind = EV_FAULT;
    else if (isPage)          evalKind = EV_FINAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iovaQ <= '0; tblAddrQ <= '0; permQ <= '0; levelQ <= '0;
      resDevId <= '0; resDomain <= '0;
    end else if (ctrl.load) begin
      iovaQ     <= reqIova;
      permQ     <= reqPerm;
      levelQ    <= rootLevel;
      tblAddrQ  <= rootAddr & ADDR_MASK;
      resDevId  <= reqDevId;
      resDomain <= reqDomain;
    end else if (ctrl.step) begin
      levelQ   <= nxt;
      tblAddrQ <= addrF;
    end
  end

  assign resIova = iovaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resStatus <= ST_OK; resPhysAddr <= '0; resPageBase <= '0; resShift <= '0;
      resPerm <= '0; resFaultType <= FT_NONE; resPresent <= 1'b0; resRsvd <= 1'b0;
      resPermDenied <= 1'b0;
    end else if (ctrl.endOk || ctrl.endFault || ctrl.endBus) begin
      resStatus     <= ctrl.endOk ? ST_OK : (ctrl.endFault ? ST_FAULT : ST_BUSERR);
      resPhysAddr   <= ctrl.endOk ? (pageBase | (iovaQ & lowMask)) : '0;
      resPageBase   <= ctrl.endOk ? pageBase : '0;
      resShift      <= ctrl.endOk ? pageShift : '0;
      resPerm       <= ctrl.endOk ? ePerm : '0;
      resFaultType  <= ctrl.endFault ? faultType : FT_NONE;
      resPresent    <= ctrl.endFault;
      resRsvd       <= ctrl.endFault && (faultType == FT_LEVEL || faultType == FT_RSVD);
      resPermDenied <= ctrl.endFault && (faultType == FT_PERM);
    end
  end
endmodule

// File: rtl/io_pt_walker.sv
module io_pt_walker
  import iopt_pkg::*;
#(
  parameter int          MAX_LEVEL = 6,
  parameter int          ID_W      = 16,
  parameter logic [63:0] ADDR_MASK = 64'h000F_FFFF_FFFF_F000,
  parameter logic [63:0] PTE_RSVD  = 64'h07F0_0000_0000_0000,
  parameter logic [63:0] PDE_RSVD  = 64'h1FF0_0000_0000_0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [63:0]     reqIova,
  input  logic [1:0]      reqPerm,
  input  logic [ID_W-1:0] reqDevId,
  input  logic [ID_W-1:0] reqDomain,
  input  logic [63:0]     rootAddr,
  input  logic [2:0]      rootLevel,
  output logic            memReqValid,
  output logic [63:0]     memReqAddr,
  input  logic            memRspValid,
  input  logic [63:0]     memRspData,
  input  logic            memRspErr,
  output logic            resValid,
  output logic [1:0]      resStatus,
  output logic [63:0]     resPhysAddr,
  output logic [63:0]     resPageBase,
  output logic [6:0]      resShift,
  output logic [1:0]      resPerm,
  output logic [2:0]      resFaultType,
  output logic            resPresent,
  output logic            resRsvd,
  output logic            resPermDenied,
  output logic [ID_W-1:0] resDevId,
  output logic [ID_W-1:0] resDomain,
  output logic [63:0]     resIova
);
  walkCtrl_t ctrl;
  evalKind_e evalKind;

  iopt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRspValid(memRspValid),
    .memRspErr(memRspErr), .evalKind(evalKind), .ctrl(ctrl), .reqReady(reqReady),
    .memReqValid(memReqValid), .resValid(resValid)
  );

  iopt_dpath #(
    .MAX_LEVEL(MAX_LEVEL), .ID_W(ID_W), .ADDR_MASK(ADDR_MASK),
    .PTE_RSVD(PTE_RSVD), .PDE_RSVD(PDE_RSVD)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqIova(reqIova), .reqPerm(reqPerm),
    .reqDevId(reqDevId), .reqDomain(reqDomain), .rootAddr(rootAddr),
    .rootLevel(rootLevel), .memRspData(memRspData), .evalKind(evalKind),
    .memReqAddr(memReqAddr), .resStatus(resStatus), .resPhysAddr(resPhysAddr),
    .resPageBase(resPageBase), .resShift(resShift), .resPerm(resPerm),
    .resFaultType(resFaultType), .resPresent(resPresent), .resRsvd(resRsvd),
    .resPermDenied(resPermDenied), .resDevId(resDevId), .resDomain(resDomain),
    .resIova(resIova)
  );
endmodule

// File: rtl/io_pt_walker_chk.sv
module io_pt_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        memReqValid,
  input logic        resValid,
  input logic [1:0]  resStatus,
  input logic [2:0]  resFaultType,
  input logic        resPresent,
  input logic        resRsvd,
  input logic        resPermDenied,
  input logic [63:0] resPageBase,
  input logic [63:0] resPhysAddr,
  input logic [6:0]  resShift
);
  p_one_read_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  p_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);
  p_res_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> (!resValid && reqReady));
  p_lvl_flags_r2: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resStatus == 2'd1 && resFaultType == 3'd1) |-> (resPresent && resRsvd && !resPermDenied));
  p_rsvd_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resStatus == 2'd1 && resFaultType == 3'd2) |-> (resRsvd && !resPermDenied));
  p_perm_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resStatus == 2'd1 && resFaultType == 3'd3) |-> (resPermDenied && !resRsvd));
  p_size_flags_r6: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resStatus == 2'd1 && resFaultType == 3'd4) |-> (resPresent && !resRsvd && !resPermDenied));
  p_base_align_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resStatus == 2'd0) |-> ((resPageBase & ~(~64'd0 << resShift)) == 64'd0));
  p_phys_top_r9: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resStatus == 2'd0) |-> ((resPhysAddr & (~64'd0 << resShift)) == resPageBase));
  p_fault_present_r10: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resStatus == 2'd1) |-> resPresent);
endmodule

bind io_pt_walker io_pt_walker_chk chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .memReqValid(memReqValid),
  .resValid(resValid), .resStatus(resStatus), .resFaultType(resFaultType),
  .resPresent(resPresent), .resRsvd(resRsvd), .resPermDenied(resPermDenied),
  .resPageBase(resPageBase), .resPhysAddr(resPhysAddr), .resShift(resShift)
);

// File: tb/io_pt_walker_tb_top.sv
module io_pt_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXL = 4;
  localparam logic [63:0] AMASK = 64'h000F_FFFF_FFFF_F000;
  localparam logic [63:0] PTEM  = 64'h07F0_0000_0000_0000;
  localparam logic [63:0] PDEM  = 64'h1FF0_0000_0000_0000;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [63:0] reqIova = '0, rootAddr = '0;
  logic [1:0] reqPerm = '0;
  logic [15:0] reqDevId = '0, reqDomain = '0;
  logic [2:0] rootLevel = 3'd1;
  logic memReqValid, memRspValid = 1'b0, memRspErr = 1'b0;
  logic [63:0] memReqAddr, memRspData = '0;
  logic resValid, resPresent, resRsvd, resPermDenied;
  logic [1:0] resStatus, resPerm;
  logic [63:0] resPhysAddr, resPageBase, resIova;
  logic [6:0] resShift;
  logic [2:0] resFaultType;
  logic [15:0] resDevId, resDomain;

  io_pt_walker #(.MAX_LEVEL(MAXL), .ID_W(16), .ADDR_MASK(AMASK), .PTE_RSVD(PTEM), .PDE_RSVD(PDEM)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqIova(reqIova),
    .reqPerm(reqPerm), .reqDevId(reqDevId), .reqDomain(reqDomain), .rootAddr(rootAddr),
    .rootLevel(rootLevel), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .memRspErr(memRspErr),
    .resValid(resValid), .resStatus(resStatus), .resPhysAddr(resPhysAddr),
    .resPageBase(resPageBase), .resShift(resShift), .resPerm(resPerm),
    .resFaultType(resFaultType), .resPresent(resPresent), .resRsvd(resRsvd),
    .resPermDenied(resPermDenied), .resDevId(resDevId), .resDomain(resDomain), .resIova(resIova)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [63:0] mem [0:4095];
  int readCnt = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  // memory model: tables at n*0x1000, addresses from 0x8000 up answer with an error
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      memRspErr   = 1'b0;
      if (rstN && memReqValid) begin
        logic [63:0] a;
        a = memReqAddr;
        readCnt++;
        repeat (1 + int'(a[4:3]) % 3) @(negedge clk);
        memRspValid = 1'b1;
        memRspErr   = (a >= 64'h8000);
        memRspData  = (a < 64'h8000) ? mem[a[14:3]] : 64'hDEAD_BEEF_0000_0000;
      end
    end
  end

  function automatic string rq(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [63:0] addr, input int code, input int perm);
    return (addr & AMASK) | (64'(code) << 9) | (64'(perm) << 61);
  endfunction

  // expected outcome of one walk, derived from the requirements
  int eStatus, eType, eReads, eTag, eShift;
  logic [63:0] eBase, ePhys;
  logic [1:0] ePerm;

  task automatic model(input logic [63:0] iova, input logic [1:0] perm, input logic [63:0] root, input int startLvl);
    int lvl, sh, n, k, up;
    logic [63:0] tbl, ea, e, af, skip;
    bit page;
    lvl = startLvl; tbl = root & AMASK; eReads = 0;
    eType = 0; eBase = 0; ePhys = 0; eShift = 0; ePerm = 0;
    for (int step = 0; step < 8; step++) begin
      sh = 3 + 9 * lvl;
      ea = tbl + ((iova >> sh) % 512) * 8;
      eReads++;
      if (ea >= 64'h8000) begin eStatus = 2; eTag = 11; return; end
      e = mem[ea[14:3]];
      n = int'(e[11:9]); af = e & AMASK; page = (n == 0 || n == 7);
      eStatus = 1;
      if (!page && n > MAXL) begin eType = 1; eTag = 2; return; end  // R2
      if ((e & (page ? PTEM : PDEM)) != 0) begin eType = 2; eTag = 3; return; end  // R3
      if ((perm & ~e[62:61]) != 0) begin eType = 3; eTag = 4; return; end  // R4
      if (page) begin
        if (n == 0) begin eShift = sh; eTag = 5; end
        else begin
          k = 12;
          while (af[k]) k++;
          eShift = k + 1;
          up = (lvl < 6) ? 3 + 9 * (lvl + 1) : 0;
          eTag = 6;
          if (!(eShift > sh && eShift < up)) begin eType = 4; eShift = 0; return; end
        end
        eStatus = 0;
        eBase = af & ~((64'd1 << eShift) - 1);
        ePhys = eBase | (iova & ((64'd1 << eShift) - 1));
        ePerm = e[62:61];
        return;
      end
      if (n >= lvl) begin eType = 5; eTag = 7; return; end  // R7
      skip = 0;
      for (int m = n + 1; m < lvl; m++) skip |= 64'd511 << (3 + 9 * m);
      if ((iova & skip) != 0) begin eType = 6; eTag = 8; return; end  // R8
      lvl = n; tbl = af;
    end
  endtask

  int walkNo = 0;

  task automatic walk(input logic [63:0] iova, input logic [1:0] perm, input logic [63:0] root,
                      input int lvl, input int forceTag);
    int cyc;
    string t;
    model(iova, perm, root, lvl);
    t = (forceTag != 0) ? rq(forceTag) : rq(eTag);
    walkNo++;
    @(negedge clk);
    readCnt   = 0;
    reqIova   = iova; reqPerm = perm; rootAddr = root; rootLevel = 3'(lvl);
    reqDevId  = 16'(walkNo); reqDomain = ~16'(walkNo);
    reqValid  = 1'b1;
    @(negedge clk);
    reqValid  = 1'b0;
    cyc = 0;
    while (!resValid && cyc < 400) begin @(negedge clk); cyc++; end
    if (!resValid) begin
      total++; bad++;
      $display("FAIL R12 walk timeout act=0 exp=1");
      return;
    end
    chk(rq(1), 64'(readCnt), 64'(eReads));           // R1 reads per level
    chk(t, 64'(resStatus), 64'(eStatus));
    if (eStatus == 0) begin
      chk(rq(9), resPhysAddr, ePhys);                // R9
      chk(t, resPageBase, eBase);
      chk(t, 64'(resShift), 64'(eShift));
      chk(rq(4), 64'(resPerm), 64'(ePerm));
    end else if (eStatus == 1) begin
      chk(t, 64'(resFaultType), 64'(eType));
      chk(t, {61'd0, resPresent, resRsvd, resPermDenied},
          {61'd0, 1'b1, 1'(eType == 1 || eType == 2), 1'(eType == 3)});
      chk(rq(10), {resDevId, resDomain}, {16'(walkNo), ~16'(walkNo)});  // R10
      chk(rq(10), resIova, iova);
    end
    @(negedge clk);
    chk(rq(12), {62'd0, resValid, reqReady}, {62'd0, 1'b0, 1'b1});      // R12
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    // table 1 (level 3 root)
    mem[512 + 0]  = mk(64'h2000, 2, 3);
    mem[512 + 1]  = mk(64'h3000, 1, 3);
    mem[512 + 2]  = mk(64'h5234_5000, 0, 1);
    mem[512 + 3]  = mk(64'h100_FFFF_F000, 7, 3);
    mem[512 + 4]  = mk(64'h3000, 7, 3);
    mem[512 + 5]  = mk(64'h2000, 5, 3);
    mem[512 + 6]  = mk(64'h2000, 2, 3) | (64'd1 << 60);
    mem[512 + 7]  = mk(64'h2000, 3, 3);
    mem[512 + 8]  = mk(64'h8000, 1, 3);
    mem[512 + 9]  = mk(64'h5000_0000, 0, 2);
    mem[512 + 10] = mk(64'h3000, 7, 3) | (64'd1 << 58);
    mem[512 + 11] = mk(64'h6000_0000, 0, 3) | (64'd1 << 59);
    for (int j = 0; j < 512; j++) begin
      // table 2 (level 2), table 4 (level 1 below it), table 3 (level 1 via skip)
      mem[1024 + j] = (j % 2 == 0) ? mk(64'h1_0000_0000 + 64'(j) * 64'h20_0000 + 64'h5000, 0, 3)
                                   : mk(64'h4000, 1, (j == 5) ? 1 : 3);
      mem[2048 + j] = mk(64'h2_0000_0000 + 64'(j) * 64'h1000, 0, 3);
      if (j % 4 == 3) mem[2048 + j] = mk(64'h2_0000_0000 + 64'(j) * 64'h2000, 7, 3);
      mem[1536 + j] = mk(64'h3_0000_0000 + 64'(j) * 64'h1000, 0, 3);
    end
    mem[1024 + 3]   = mk(64'h000F_F000, 7, 3);
    mem[1024 + 511] = mk(64'h1_007F_F000, 7, 3);
    mem[2048 + 7]   = mk(64'h001F_F000, 7, 3);
    mem[2048 + 1]   = mk(64'h2_0000_1000, 0, 3) | (64'd1 << 59);
    mem[2048 + 511] = mk(64'h3000, 2, 3);
    // table 5 (level 4 root)
    mem[2560 + 0] = mk(64'h1000, 3, 3);
    mem[2560 + 1] = mk(64'h3000, 1, 3);
    mem[2560 + 2] = mk(64'h80_0000_0000, 0, 3);
    mem[2560 + 3] = mk(64'h1000, 6, 3);
    mem[2560 + 4] = mk(64'h1000, 4, 3);

    repeat (3) @(negedge clk);
    chk(rq(12), {61'd0, reqReady, resValid, memReqValid}, {61'd0, 1'b1, 1'b0, 1'b0});
    rstN = 1'b1;
    @(negedge clk);
    chk(rq(12), {61'd0, reqReady, resValid, memReqValid}, {61'd0, 1'b1, 1'b0, 1'b0});

    // R13: reserved bits reported ahead of a bad page size
    walk(64'd10 << 30, 2'd0, 64'h1000, 3, 13);

    begin
      int a2s[6] = '{0, 1, 2, 3, 5, 511};
      int a1s[5] = '{0, 1, 3, 7, 511};
      for (int a3 = 0; a3 < 12; a3++)
        for (int i2 = 0; i2 < 6; i2++)
          for (int i1 = 0; i1 < 5; i1++)
            for (int p = 0; p < 4; p++)
              walk((64'(a3) << 30) | (64'(a2s[i2]) << 21) | (64'(a1s[i1]) << 12),
                   2'(p), 64'h1000, 3, 0);
    end
    begin
      int a3s[3] = '{0, 2, 8};
      for (int a4 = 0; a4 < 6; a4++)
        for (int i3 = 0; i3 < 3; i3++)
          for (int a2 = 0; a2 < 2; a2++)
            for (int a1 = 0; a1 < 4; a1 += 3)
              for (int p = 0; p < 4; p++)
                walk((64'(a4) << 39) | (64'(a3s[i3]) << 30) | (64'(a2) << 21) | (64'(a1) << 12),
                     2'(p), 64'h5000, 4, 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule